// File: doc/BRIEF.md
# Flash Word Program Sequencer

This block sits on the host side of a NOR-style flash device and writes a single word into it on request. The caller offers an even word address and a data word on a valid/ready port. Once the request is taken, the sequencer drives the four-write program command onto a synchronous strobe bus. The first three writes are fixed unlock and program codes. The fourth write carries the caller's address and data. After that, the sequencer polls the device's status word at that same address until the embedded write ends.

Completion is judged by comparing status bit 7 with bit 7 of the word being written. Status bit 5 signals that the device has run past its internal time limit. Bits 5 and 7 change in the same device cycle, so a set bit 5 does not count as a failure by itself: one more status read is made, and bit 7 is compared again. A failure, whether from that confirmed timeout or from the host's own cap on poll reads, ends with a reset-to-read-mode write to the device. The block then reports the outcome with a one-cycle pulse. A request with an odd address is refused at once and causes no bus activity. To write several words, the caller makes several requests.

Top module: `fpgm_seq`

## Requirements
- R1: The cycle after an even-address request is accepted, the block issues four write strobes on consecutive cycles. Their (address, data) pairs are, in order: (UNLK_A, 0x00AA), (UNLK_B, 0x0055), (UNLK_A, 0x00A0), (request address, request data). The defaults are UNLK_A = 0xAAAA and UNLK_B = 0x5554.
- R2: A request whose address bit 0 is 1 is refused. The block pulses `rej_o` for one cycle in the cycle after acceptance and issues no write or read strobe. `req_ready_o` stays high.
- R3: Each request programs exactly one word. Between requests the block makes no bus activity. A second request repeats the full four-write sequence.
- R4: Every status read is made to the address that was just programmed. The first read strobe comes in the cycle after the fourth command write, and read data is taken one cycle after each read strobe.
- R5: When a sampled status word has bit 7 equal to bit 7 of the written data, `done_o` pulses for one cycle in the next cycle. This holds for both polarities of data bit 7.
- R6: If a sampled status word has bit 7 mismatched and bit 5 set, the block makes exactly one more status read. If bit 7 then matches, the outcome is done, not fail.
- R7: If bit 7 still mismatches on that confirming read, the block writes 0x00F0 to the target address in the cycle after the sample. It then pulses `fail_o` in the following cycle.
- R8: After POLL_LIMIT status reads that show neither a match nor bit 5 set, the block issues the 0x00F0 reset write and then pulses `fail_o`. It never makes more than POLL_LIMIT ordinary poll reads.
- R9: `req_ready_o` is low from the cycle after an even-address request is accepted until the cycle in which `done_o` or `fail_o` pulses. Requests offered while it is low have no effect on the bus.
- R10: After reset, `req_ready_o` is 1, and both strobes, `done_o`, `fail_o` and `rej_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_addr_i | input | AW | Target word address (must be even) |
| req_data_i | input | DW | Word to program |
| done_o | output | 1 | One-cycle pulse: word programmed |
| fail_o | output | 1 | One-cycle pulse: program failed |
| rej_o | output | 1 | One-cycle pulse: odd address refused |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | DW | Flash write data |
| fl_rdata_i | input | DW | Flash read data, valid the cycle after `fl_re_o` |

## Verification
The hardest outcomes to reach are the two that follow a set timeout bit: a confirming read that succeeds, and one that fails. They depend on what the device returns, read by read, after the command has been written. The bench therefore contains a scripted flash model. It counts reads and returns an inverted bit 7 for a chosen number of reads, and raises bit 5 from a chosen read index onward. This makes the bit-5 read fall exactly one read before the match in one test, and leaves the match out entirely in another. The watchdog path is reached the same way, with the bench's poll limit lowered to 8 so that a device that never finishes exhausts the count quickly.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_POLL_RD,
        S_POLL_CHK,
        S_RECHK_RD,
        S_RECHK_CHK,
        S_RST_WR
    } fpgm_state_e;

    localparam int NCMD = 4;
    localparam int STEP_W = $clog2(NCMD);

    localparam logic [7:0] CODE_UNLK1 = 8'hAA;
    localparam logic [7:0] CODE_UNLK2 = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_RESET = 8'hF0;

    localparam int BIT_DONE = 7;
    localparam int BIT_TMO  = 5;

endpackage

// File: rtl/fpgm_cmd_gen.sv
module fpgm_cmd_gen
    import fpgm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter logic [AW-1:0] UNLK_A = 'hAAAA,
    parameter logic [AW-1:0] UNLK_B = 'h5554
) (
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     cmd_addr,
    output logic [DW-1:0]     cmd_data
);
    always_comb begin
        case (step)
            STEP_W'(0): begin
                cmd_addr = UNLK_A;
                cmd_data = DW'(CODE_UNLK1);
            end
            STEP_W'(1): begin
                cmd_addr = UNLK_B;
                cmd_data = DW'(CODE_UNLK2);
            end
            STEP_W'(2): begin
                cmd_addr = UNLK_A;
                cmd_data = DW'(CODE_PROG);
            end
            default: begin
                cmd_addr = tgt_addr;
                cmd_data = tgt_data;
            end
        endcase
    end
endmodule

// File: rtl/fpgm_poll_eval.sv
module fpgm_poll_eval
    import fpgm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] status,
    input  logic          exp_bit,
    output logic          match,
    output logic          tmo
);
    logic unused_status;
    assign unused_status = ^status;
    assign match = (status[BIT_DONE] == exp_bit);
    assign tmo   = status[BIT_TMO];
endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
    import fpgm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int POLL_LIMIT = 1024,
    parameter logic [AW-1:0] UNLK_A = 'hAAAA,
    parameter logic [AW-1:0] UNLK_B = 'h5554
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_data_i,
    output logic          done_o,
    output logic          fail_o,
    output logic          rej_o,
    output logic          fl_we_o,
    output logic          fl_re_o,
    output logic [AW-1:0] fl_addr_o,
    output logic [DW-1:0] fl_wdata_o,
    input  logic [DW-1:0] fl_rdata_i
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        fpgm_state_e        state;
        logic [STEP_W-1:0]  step;
        logic [AW-1:0]      tgt_addr;
        logic [DW-1:0]      tgt_data;
        logic [CW-1:0]      cnt;
        logic               done;
        logic               fail;
        logic               rej;
    } seq_t;

    seq_t q, d;

    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          st_match;
    logic          st_tmo;

    fpgm_cmd_gen #(
        .AW(AW), .DW(DW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)
    ) u_cmd (
        .step     (q.step),
        .tgt_addr (q.tgt_addr),
        .tgt_data (q.tgt_data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    fpgm_poll_eval #(.DW(DW)) u_eval (
        .status  (fl_rdata_i),
        .exp_bit (q.tgt_data[BIT_DONE]),
        .match   (st_match),
        .tmo     (st_tmo)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.fail = 1'b0;
        d.rej  = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (req_valid_i) begin
                    if (req_addr_i[0]) begin
                        d.rej = 1'b1;
                    end else begin
                        d.state    = S_CMD;
                        d.step     = '0;
                        d.tgt_addr = req_addr_i;
                        d.tgt_data = req_data_i;
                        d.cnt      = '0;
                    end
                end
            end
            S_CMD: begin
                if (q.step == STEP_W'(NCMD - 1)) d.state = S_POLL_RD;
                else                             d.step  = q.step + 1'b1;
            end
            S_POLL_RD: begin
                d.cnt   = q.cnt + 1'b1;
                d.state = S_POLL_CHK;
            end
            S_POLL_CHK: begin
                if (st_match) begin
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else if (st_tmo) begin
                    d.state = S_RECHK_RD;
                end else if (q.cnt == CW'(POLL_LIMIT)) begin
                    d.state = S_RST_WR;
                end else begin
                    d.state = S_POLL_RD;
                end
            end
            S_RECHK_RD: d.state = S_RECHK_CHK;
            S_RECHK_CHK: begin
                if (st_match) begin
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.state = S_RST_WR;
                end
            end
            S_RST_WR: begin
                d.fail  = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = (q.state == S_IDLE);
    assign done_o      = q.done;
    assign fail_o      = q.fail;
    assign rej_o       = q.rej;
    assign fl_we_o     = (q.state == S_CMD) || (q.state == S_RST_WR);
    assign fl_re_o     = (q.state == S_POLL_RD) || (q.state == S_RECHK_RD);
    assign fl_addr_o   = (q.state == S_CMD) ? cmd_addr : q.tgt_addr;
    assign fl_wdata_o  = (q.state == S_CMD)    ? cmd_data :
                         (q.state == S_RST_WR) ? DW'(CODE_RESET) : '0;

    p_first_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !req_addr_i[0]) |=>
            (fl_we_o && fl_addr_o == UNLK_A && fl_wdata_o == DW'(CODE_UNLK1)));

    p_odd_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_addr_i[0]) |=>
            (rej_o && !fl_we_o && !fl_re_o && req_ready_o));

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_re_o));

    p_read_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re_o |-> (fl_addr_o == q.tgt_addr && !fl_addr_o[0]));

    p_done_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(fl_rdata_i[BIT_DONE]) == q.tgt_data[BIT_DONE]));

    p_fail_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> ($past(fl_we_o) && $past(fl_wdata_o) == DW'(CODE_RESET)));

    p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(POLL_LIMIT));

    p_busy_until_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> $past(!req_ready_o));

endmodule

// File: tb/sim_fpgm_seq.sv
module sim_fpgm_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic done, fail, rej;
    logic fl_we, fl_re;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata = '0;

    always #10 clk = ~clk;

    fpgm_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_data_i(req_data),
        .done_o(done), .fail_o(fail), .rej_o(rej),
        .fl_we_o(fl_we), .fl_re_o(fl_re), .fl_addr_o(fl_addr),
        .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // scripted flash model
    int busy_n = 0;
    int dq5_from = 1000;
    int rd_idx = 0;
    logic m_d7 = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fl_re) begin
            fl_rdata <= {8'h00, ((rd_idx >= busy_n) ? m_d7 : ~m_d7), 1'b0,
                         (rd_idx >= dq5_from), 5'b0};
            rd_idx <= rd_idx + 1;
        end
    end

    // bus monitor
    logic [AW-1:0] wa [0:15];
    logic [DW-1:0] wd [0:15];
    int wcyc [0:15];
    int nw = 0;
    int nr = 0;
    int bad_raddr = 0;
    int first_rd = -1;
    logic [AW-1:0] exp_tgt = '0;

    always @(negedge clk) begin
        if (fl_we) begin
            if (nw < 16) begin
                wa[nw] = fl_addr;
                wd[nw] = fl_wdata;
                wcyc[nw] = cyc;
            end
            nw = nw + 1;
        end
        if (fl_re) begin
            if (nr == 0) first_rd = cyc;
            nr = nr + 1;
            if (fl_addr != exp_tgt) bad_raddr = bad_raddr + 1;
        end
    end

    initial begin
        #4000000;
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run did not end (actual hung, expected finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon(input int bn, input int d5, input logic [AW-1:0] tgt, input logic d7);
        @(negedge clk);
        nw = 0; nr = 0; bad_raddr = 0; first_rd = -1;
        busy_n = bn; dq5_from = d5; rd_idx = 0; m_d7 = d7; exp_tgt = tgt;
    endtask

    // kind: 1 done, 2 fail, 3 rej, 0 none
    task automatic do_req(input logic [AW-1:0] a, input logic [DW-1:0] dt, input bit spam,
                          output int kind, output int acc, output int res_cyc, output int rdy_busy);
        kind = 0; res_cyc = -1; rdy_busy = 0;
        @(negedge clk);
        req_addr = a; req_data = dt; req_valid = 1'b1;
        @(negedge clk);
        acc = cyc;
        req_valid = spam;
        if (spam) begin
            req_addr = a ^ 16'h0100;
            req_data = ~dt;
        end
        for (int i = 0; i < 200; i++) begin
            if (done || fail || rej) begin
                kind = done ? 1 : (fail ? 2 : 3);
                res_cyc = cyc;
                req_valid = 1'b0;
                break;
            end
            if (req_ready) rdy_busy = rdy_busy + 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic chk_cmd(input logic [AW-1:0] a, input logic [DW-1:0] dt, input int acc, input string tag);
        logic [AW-1:0] ea [0:3];
        logic [DW-1:0] ed [0:3];
        ea[0] = 16'hAAAA; ed[0] = 16'h00AA;
        ea[1] = 16'h5554; ed[1] = 16'h0055;
        ea[2] = 16'hAAAA; ed[2] = 16'h00A0;
        ea[3] = a;        ed[3] = dt;
        for (int k = 0; k < 4; k++) begin
            chk(wa[k] == ea[k] && wd[k] == ed[k] && wcyc[k] == acc + k,
                {tag, " R1 command write"}, {wa[k], wd[k]}, {ea[k], ed[k]});
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready && !fl_we && !fl_re && !done && !fail && !rej, "R10 reset state",
            {req_ready, fl_we, fl_re, done, fail, rej}, 6'b100000);
    endtask

    task automatic t_basic;
        int k, acc, rc, rb;
        clr_mon(2, 1000, 16'h1234, 1'b1);
        do_req(16'h1234, 16'hBEEF, 1'b0, k, acc, rc, rb);
        chk(k == 1, "R5 done outcome", k, 1);
        chk(nw == 4, "R3 write count", nw, 4);
        chk_cmd(16'h1234, 16'hBEEF, acc, "basic");
        chk(first_rd == acc + 4, "R4 first read cycle", first_rd, acc + 4);
        chk(nr == 3 && bad_raddr == 0, "R4 reads at target", nr, 3);
        chk(rc == acc + 10, "R5 done cycle", rc, acc + 10);
        chk(rb == 0, "R9 ready low while busy", rb, 0);
    endtask

    task automatic t_polarity;
        int k, acc, rc, rb;
        clr_mon(0, 1000, 16'h0040, 1'b0);
        do_req(16'h0040, 16'h7F01, 1'b0, k, acc, rc, rb);
        chk(k == 1 && rc == acc + 6, "R5 bit7=0 immediate done", rc, acc + 6);
        chk(nr == 1, "R5 single read", nr, 1);
    endtask

    task automatic t_odd;
        int k, acc, rc, rb;
        clr_mon(0, 1000, 16'h0033, 1'b0);
        do_req(16'h0033, 16'h1111, 1'b0, k, acc, rc, rb);
        chk(k == 3 && rc == acc, "R2 reject pulse", rc, acc);
        chk(req_ready == 1'b1, "R2 ready stays high", req_ready, 1);
        repeat (6) @(negedge clk);
        chk(nw == 0 && nr == 0, "R2 no bus activity", nw + nr, 0);
    endtask

    task automatic t_back_to_back;
        int k, acc, rc, rb;
        clr_mon(1, 1000, 16'h2000, 1'b0);
        do_req(16'h2000, 16'h0011, 1'b0, k, acc, rc, rb);
        repeat (5) @(negedge clk);
        chk(nw == 4 && nr == 2, "R3 idle after done", nw * 16 + nr, 66);
        clr_mon(1, 1000, 16'h2002, 1'b1);
        do_req(16'h2002, 16'h8022, 1'b0, k, acc, rc, rb);
        chk(k == 1 && nw == 4, "R3 second word", nw, 4);
        chk_cmd(16'h2002, 16'h8022, acc, "second");
    endtask

    task automatic t_busy_ignored;
        int k, acc, rc, rb;
        clr_mon(3, 1000, 16'h0100, 1'b1);
        do_req(16'h0100, 16'h8000, 1'b1, k, acc, rc, rb);
        repeat (3) @(negedge clk);
        chk(k == 1 && nw == 4 && bad_raddr == 0, "R9 busy requests ignored", nw, 4);
        chk(wa[3] == 16'h0100 && wd[3] == 16'h8000, "R9 target unchanged", wa[3], 16'h0100);
    endtask

    task automatic t_recheck_ok;
        int k, acc, rc, rb;
        clr_mon(3, 2, 16'h0ABC, 1'b1);
        do_req(16'h0ABC, 16'hC3C3, 1'b0, k, acc, rc, rb);
        chk(k == 1, "R6 recheck gives done", k, 1);
        chk(nr == 4 && nw == 4, "R6 one extra read no reset", nr * 16 + nw, 68);
        chk(rc == acc + 12, "R6 done cycle", rc, acc + 12);
    endtask

    task automatic t_recheck_fail;
        int k, acc, rc, rb;
        clr_mon(100, 1, 16'h0F00, 1'b0);
        do_req(16'h0F00, 16'h0042, 1'b0, k, acc, rc, rb);
        chk(k == 2 && rc == acc + 11, "R7 fail pulse cycle", rc, acc + 11);
        chk(nr == 3, "R6 reads on timeout", nr, 3);
        chk(nw == 5 && wa[4] == 16'h0F00 && wd[4] == 16'h00F0 && wcyc[4] == acc + 10,
            "R7 reset write", wd[4], 16'h00F0);
    endtask

    task automatic t_timeout;
        int k, acc, rc, rb;
        clr_mon(1000, 1000, 16'h4444, 1'b1);
        do_req(16'h4444, 16'hFFFF, 1'b0, k, acc, rc, rb);
        chk(nr == LIM, "R8 poll read count", nr, LIM);
        chk(k == 2 && rc == acc + 21, "R8 fail cycle", rc, acc + 21);
        chk(nw == 5 && wd[4] == 16'h00F0 && wa[4] == 16'h4444, "R8 reset write", wd[4], 16'h00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_polarity();
        t_odd();
        t_back_to_back();
        t_busy_ignored();
        t_recheck_ok();
        t_recheck_fail();
        t_timeout();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule